// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four external interrupt pins and turns them into request lines for an interrupt controller. A single 32-bit control word configures all four pins. For each pin it holds an enable bit and a two-bit sense selection, and it accepts a write-one clear command. Shared bits in the same word provide a master enable that gates every external request and a critical-routing flag. That flag is passed straight out to the routing logic downstream.

Each pin is first synchronized to the block clock. In a level sense the request follows the synchronized pin, either as driven or inverted. In an edge sense a detected rising or falling transition is held in a pending flag until software writes a one to that pin's clear bit. Pin 0 drives the critical-group request. Pins 1 to 3 drive the three main-group request lines. Software writes the whole word with one strobe and reads it back at any time.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset the control word reads 0, every request output is low and `route_normal` is low.
- R2: A write stores all 32 bits of `wr_data`. On read-back, bits 27..24 always read 0 and every other bit returns its last written value.
- R3: Bit (11 - n) enables pin n when 1. While it is 0, the request for pin n stays low.
- R4: Bit 12 is a master enable. While it is 0, no request output is high.
- R5: The sense field for pin n is bits (23 - 2n):(22 - 2n). Code 0 (level high) makes the request equal the pin value delayed by the two-stage synchronizer.
- R6: Sense code 3 (level low) makes the request equal the inverted synchronized pin.
- R7: Sense code 1 (rising edge) sets a pending flag on a synchronized 0-to-1 transition. The flag stays set after the pin falls again.
- R8: Sense code 2 (falling edge) sets the pending flag on a synchronized 1-to-0 transition and holds it.
- R9: Writing 1 to bit (27 - n) clears the pending flag of pin n only. An edge detected in the same cycle as the clear wins, and the flag stays set.
- R10: In a level sense, writing the clear bit has no effect on the request.
- R11: Pin 0 drives `crit_req`. Pins 1, 2 and 3 drive `main_req[0]`, `main_req[1]` and `main_req[2]`. Bit 0 of the control word drives `route_normal`.
- R12: Edges are captured while a pin is disabled, and a pending edge appears on the request once the pin is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read-back |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| crit_req | output | 1 | Critical-group request from pin 0 |
| main_req | output | 3 | Main-group requests from pins 1 to 3 |
| route_normal | output | 1 | Critical-routing flag from bit 0 |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a newly detected edge, because the edge surfaces only after the synchronizer delay. The bench raises the pin on a falling clock edge and waits exactly two cycles. It then issues the clear strobe so that the clear and the edge detection meet at the same rising edge, and it checks that the request survives. The rest of the stimulus sweeps every pin across every sense code under each enable and master combination, with a fixed low-high-low-clear pin sequence.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NUM_PINS   = 4;
    localparam int CTRL_W     = 32;
    localparam int MASTER_BIT = 12;
    localparam int ROUTE_BIT  = 0;
    localparam int EN_TOP     = 11;
    localparam int CLR_TOP    = 27;
    localparam int SENSE_TOP  = 23;

    typedef enum logic [1:0] {
        SENSE_HIGH = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    function automatic int en_bit(input int n);
        return EN_TOP - n;
    endfunction

    function automatic int clr_bit(input int n);
        return CLR_TOP - n;
    endfunction

    function automatic int sense_lsb(input int n);
        return SENSE_TOP - 1 - 2 * n;
    endfunction

    function automatic logic [CTRL_W-1:0] clr_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            m[clr_bit(i)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [CTRL_W-1:0] CLR_MASK = clr_mask();

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync_i,
    input  sense_e sense_i,
    input  logic   enable_i,
    input  logic   master_i,
    input  logic   clear_i,
    output logic   req_o
);

    typedef struct packed {
        logic prev;
        logic pend;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic       rise_w, fall_w, hit_w, active_w;

    always_comb begin
        rise_w  = sync_i & ~st_q.prev;
        fall_w  = ~sync_i & st_q.prev;
        hit_w   = ((sense_i == SENSE_RISE) & rise_w) |
                  ((sense_i == SENSE_FALL) & fall_w);
        st_d.prev = sync_i;
        // a fresh edge outranks a simultaneous clear
        st_d.pend = hit_w | (st_q.pend & ~clear_i);
        unique case (sense_i)
            SENSE_HIGH: active_w = sync_i;
            SENSE_LOW:  active_w = ~sync_i;
            default:    active_w = st_q.pend;
        endcase
        req_o = enable_i & master_i & active_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [3:0]  pin_in,
    output logic        crit_req,
    output logic [2:0]  main_req,
    output logic        route_normal
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_state_t;

    top_state_t            st_d, st_q;
    logic [NUM_PINS-1:0]   clr_w;
    logic [NUM_PINS-1:0]   sync_w;
    logic [NUM_PINS-1:0]   req_w;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = wr_data & ~CLR_MASK;
        end
        for (int i = 0; i < NUM_PINS; i++) begin
            clr_w[i] = wr_en & wr_data[clr_bit(i)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ext_irq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_w)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        ext_irq_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_w[n]),
            .sense_i  (sense_e'(st_q.ctrl[sense_lsb(n) +: 2])),
            .enable_i (st_q.ctrl[en_bit(n)]),
            .master_i (st_q.ctrl[MASTER_BIT]),
            .clear_i  (clr_w[n]),
            .req_o    (req_w[n])
        );
    end

    assign rd_data      = st_q.ctrl;
    assign crit_req     = req_w[0];
    assign main_req     = req_w[NUM_PINS-1:1];
    assign route_normal = st_q.ctrl[ROUTE_BIT];

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
    import ext_irq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        crit_req,
    input logic [2:0]  main_req
);

    logic [NUM_PINS-1:0] req_v;
    assign req_v = {main_req, crit_req};

    assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & ~CLR_MASK));

    assert_master_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[MASTER_BIT] |-> req_v == '0);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        logic [1:0] field_w;
        logic       edge_w;
        assign field_w = rd_data[sense_lsb(n) +: 2];
        assign edge_w  = (field_w == 2'd1) || (field_w == 2'd2);

        assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[en_bit(n)] |-> !req_v[n]);

        // R7 / R8: an edge request persists until a write arrives
        assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_v[n] && edge_w && !wr_en) |=> req_v[n]);
    end

endmodule

bind ext_irq_sense_ctrl ext_irq_sense_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .crit_req (crit_req),
    .main_req (main_req)
);

// File: tb/ext_irq_sense_ctrl_test.sv
module ext_irq_sense_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  pin_in = '0;
    logic        crit_req;
    logic [2:0]  main_req;
    logic        route_normal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ext_irq_sense_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .pin_in       (pin_in),
        .crit_req     (crit_req),
        .main_req     (main_req),
        .route_normal (route_normal)
    );

    function automatic logic [3:0] reqv();
        return {main_req, crit_req};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic settle(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [31:0] cfg(input int n, input int m, input bit e, input bit ms);
        logic [31:0] w;
        w = '0;
        w[12] = ms;
        w[11 - n] = e;
        w[(22 - 2*n) +: 2] = m[1:0];
        return w;
    endfunction

    function automatic string tag_for(input int m, input bit e, input bit ms, input int ph);
        if (!e)  return "R3";
        if (!ms) return "R4";
        if (ph == 3) return (m == 0 || m == 3) ? "R10" : "R9";
        case (m)
            0: return "R5";
            3: return "R6";
            1: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic bit exp_active(input int m, input int ph);
        case (ph)
            0: return m == 3;
            1: return m == 0 || m == 1;
            2: return m != 0;
            default: return m == 3;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        settle(2);
        rst_n = 1'b1;
        settle(1);
        // R1: reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 requests", {28'h0, reqv()}, 32'h0);
        check("R1 route_normal", {31'h0, route_normal}, 32'h0);

        // R2: read-back with clear bits forced to zero
        wr(32'hFFFF_FFFF);
        check("R2 all ones", rd_data, 32'hF0FF_FFFF);
        wr(32'hA5A5_A5A5);
        check("R2 pattern", rd_data, 32'hA0A5_A5A5);
        wr(32'h0F00_0000);
        check("R2 clear only", rd_data, 32'h0);

        // R3 R4 R5 R6 R7 R8 R9 R10: sweep pins, sense codes, gates
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 4; m++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int ms = 0; ms < 2; ms++) begin
                        logic [31:0] c;
                        bit          g;
                        c = cfg(n, m, e[0], ms[0]);
                        g = e[0] && ms[0];
                        pin_in = '0;
                        wr(c | 32'h0F00_0000);
                        settle(4);
                        for (int ph = 0; ph < 4; ph++) begin
                            if (ph == 1) begin pin_in[n] = 1'b1; settle(4); end
                            if (ph == 2) begin pin_in[n] = 1'b0; settle(4); end
                            if (ph == 3) begin wr(c | (32'h1 << (27 - n))); settle(1); end
                            check($sformatf("%s pin%0d sense%0d en%0d m%0d ph%0d",
                                            tag_for(m, e[0], ms[0], ph), n, m, e, ms, ph),
                                  {28'h0, reqv()},
                                  {28'h0, 4'((g && exp_active(m, ph)) ? (1 << n) : 0)});
                        end
                    end
                end
            end
        end

        // R11: routing of pins to group outputs and the routing flag
        pin_in = '0;
        wr(32'h0000_1F01);
        pin_in = 4'b1010;
        settle(4);
        check("R11 crit_req", {31'h0, crit_req}, 32'h0);
        check("R11 main_req", {29'h0, main_req}, 32'h5);
        check("R11 route_normal", {31'h0, route_normal}, 32'h1);
        pin_in = 4'b0001;
        settle(4);
        check("R11 crit only", {28'h0, reqv()}, 32'h1);

        // R9: clear of one pin leaves the other pending
        pin_in = '0;
        wr(cfg(0, 1, 1, 1) | cfg(1, 1, 1, 1) | 32'h0F00_0000);
        settle(4);
        pin_in = 4'b0011;
        settle(4);
        pin_in = 4'b0000;
        settle(4);
        check("R9 both pending", {28'h0, reqv()}, 32'h3);
        wr(cfg(0, 1, 1, 1) | cfg(1, 1, 1, 1) | 32'h0800_0000);
        settle(1);
        check("R9 isolated clear", {28'h0, reqv()}, 32'h2);

        // R9: same-cycle edge and clear, edge wins
        wr(cfg(1, 1, 1, 1) | 32'h0F00_0000);
        settle(2);
        pin_in[1] = 1'b1;
        settle(2);
        wr(cfg(1, 1, 1, 1) | 32'h0400_0000);
        settle(1);
        check("R9 edge beats clear", {28'h0, reqv()}, 32'h2);
        pin_in[1] = 1'b0;

        // R12: edge captured while disabled appears on enable
        wr(cfg(2, 1, 0, 1) | 32'h0F00_0000);
        settle(4);
        pin_in[2] = 1'b1;
        settle(4);
        pin_in[2] = 1'b0;
        settle(4);
        check("R12 hidden while disabled", {28'h0, reqv()}, 32'h0);
        wr(cfg(2, 1, 1, 1));
        settle(1);
        check("R12 visible after enable", {28'h0, reqv()}, 32'h4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule